// File: doc/BRIEF.md
# Vector Register Shape Tracker

This block keeps a small piece of metadata next to every architectural vector register of a SIMT core. The metadata records the shape of the register's value across lanes. A register can be uniform, with the same value in every lane. It can be affine, where lane t holds base + t × stride. Otherwise its shape is unknown. Uniform and affine registers also keep the compact pair (base, stride). The full per-lane contents are held elsewhere.

For each issued instruction, the tracker reads the shapes of the source registers and works out the shape and compact pair of the destination. It writes the destination entry at the same clock edge that registers the result. It also reports three things about the instruction:
- whether it can run once as a scalar operation,
- whether a memory access can go out as one contiguous vector access instead of a per-lane gather or scatter,
- whether that access is unit-strided.

The supported operations are thread-index move, immediate move, add, multiply, load and store.

Top module: `vshape_tracker`

## Requirements
- R1: While reset is high and after it is released, every register entry holds the unknown tag (encoding U=0, A=1, K=2), and `res_valid` is low during reset.
- R2: A thread-index move (op 0) writes the destination as affine with base 0 and stride 1.
- R3: An immediate move (op 1) writes the destination as uniform with base equal to the immediate and stride 0, and flags the result scalar.
- R4: Add (op 2) of two shaped sources adds the bases and adds the strides. The result is uniform when both sources are uniform, and affine otherwise.
- R5: Multiply (op 3) of uniform × uniform gives uniform with the product of the bases. Uniform × affine, in either order, gives affine with both the base and the stride of the affine source multiplied by the uniform value.
- R6: Affine × affine, and any add or multiply with an unknown source, gives unknown with base and stride reported as 0.
- R7: The scalar flag is set exactly for immediate moves and for adds or multiplies whose two sources are both uniform.
- R8: A load (op 4) writes its destination as unknown. Its vector-access flag is set when the address register (source A) is affine. Its unit-stride flag is set when, in addition, the address stride equals ELEM_BYTES (default 4).
- R9: A store (op 5, address in source A) reports the same vector-access and unit-stride flags as a load, reports tag K with zero base and stride, and leaves every register entry unchanged, including the one named by `dst_idx`.
- R10: Each result appears on the outputs exactly one cycle after the issue cycle. An instruction issued in the very next cycle already reads the updated destination entry.
- R11: Opcodes 6 and 7 produce no result and write no register entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_op | input | 3 | Opcode: 0 tid move, 1 immediate, 2 add, 3 multiply, 4 load, 5 store |
| dst_idx | input | 4 | Destination register |
| src_a_idx | input | 4 | First source register (address for load/store) |
| src_b_idx | input | 4 | Second source register |
| imm | input | 32 | Immediate for op 1 |
| res_valid | output | 1 | Result outputs are valid |
| res_tag | output | 2 | Shape of the destination (U=0, A=1, K=2) |
| res_base | output | 32 | Compact base of the destination |
| res_stride | output | 32 | Compact stride of the destination |
| res_scalar | output | 1 | Instruction may run once as a scalar operation |
| res_vec_access | output | 1 | Memory address is affine, so no gather or scatter is needed |
| res_unit_stride | output | 1 | Affine address stride equals the element size |

## Verification
Every result is due on the outputs one clock edge after its issue cycle. No result is produced for opcodes 6 and 7. The driver places instructions on the falling edge and pushes the expected result into a queue at that moment. The monitor samples just after each rising edge, so each item it pops belongs to the instruction captured at that edge. Back-to-back instructions that read the previous destination show that the entry write lands within that same edge. Any result the monitor sees with an empty queue is counted as a failure, and so is an item left in the queue at the end.

// File: rtl/shape_pkg.sv
package shape_pkg;

    parameter int DATA_W = 32;
    parameter int NREG   = 16;
    localparam int IDX_W = $clog2(NREG);

    typedef enum logic [1:0] {
        SH_UNI = 2'd0,
        SH_AFF = 2'd1,
        SH_UNK = 2'd2
    } shape_tag_e;

    typedef enum logic [2:0] {
        OP_TID   = 3'd0,
        OP_IMM   = 3'd1,
        OP_ADD   = 3'd2,
        OP_MUL   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5
    } shape_op_e;

    typedef struct packed {
        shape_tag_e        tag;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] stride;
    } shape_t;

    typedef struct packed {
        logic   valid;
        logic   wr_en;
        shape_t dst;
        logic   scalar;
        logic   vec_access;
        logic   unit_stride;
    } shape_res_t;

    function automatic shape_t shape_unknown();
        shape_t s;
        s.tag    = SH_UNK;
        s.base   = '0;
        s.stride = '0;
        return s;
    endfunction

    function automatic logic is_legal_op(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

endpackage

// File: rtl/vshape_file.sv
module vshape_file
    import shape_pkg::*;
#(
    parameter int N_ENTRIES = NREG,
    localparam int AW       = $clog2(N_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  shape_t        wr_data,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output shape_t        rd_a,
    output shape_t        rd_b
);

    shape_t entries [N_ENTRIES];

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    entries[g] <= shape_unknown();
                end else if (wr_en && (wr_idx == AW'(g))) begin
                    entries[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_a = entries[rd_a_idx];
    assign rd_b = entries[rd_b_idx];

endmodule

// File: rtl/vshape_alu.sv
module vshape_alu
    import shape_pkg::*;
#(
    parameter int ELEM_BYTES = 4
) (
    input  logic              valid,
    input  logic [2:0]        op,
    input  shape_t            src_a,
    input  shape_t            src_b,
    input  logic [DATA_W-1:0] imm,
    output shape_res_t        res
);

    logic a_uni, b_uni, a_aff, b_aff, a_shaped, b_shaped;
    logic addr_aff;

    assign a_uni    = (src_a.tag == SH_UNI);
    assign b_uni    = (src_b.tag == SH_UNI);
    assign a_aff    = (src_a.tag == SH_AFF);
    assign b_aff    = (src_b.tag == SH_AFF);
    assign a_shaped = a_uni | a_aff;
    assign b_shaped = b_uni | b_aff;
    assign addr_aff = a_aff;

    always_comb begin
        res             = '0;
        res.dst         = shape_unknown();
        res.valid       = valid && is_legal_op(op);
        res.wr_en       = 1'b0;
        if (valid) begin
            unique case (op)
                OP_TID: begin
                    res.wr_en      = 1'b1;
                    res.dst.tag    = SH_AFF;
                    res.dst.base   = '0;
                    res.dst.stride = DATA_W'(1);
                end
                OP_IMM: begin
                    res.wr_en      = 1'b1;
                    res.dst.tag    = SH_UNI;
                    res.dst.base   = imm;
                    res.dst.stride = '0;
                    res.scalar     = 1'b1;
                end
                OP_ADD: begin
                    res.wr_en = 1'b1;
                    if (a_shaped && b_shaped) begin
                        res.dst.tag    = (a_uni && b_uni) ? SH_UNI : SH_AFF;
                        res.dst.base   = src_a.base + src_b.base;
                        res.dst.stride = src_a.stride + src_b.stride;
                        res.scalar     = a_uni && b_uni;
                    end
                end
                OP_MUL: begin
                    res.wr_en = 1'b1;
                    if (a_uni && b_uni) begin
                        res.dst.tag    = SH_UNI;
                        res.dst.base   = src_a.base * src_b.base;
                        res.dst.stride = '0;
                        res.scalar     = 1'b1;
                    end else if (a_uni && b_aff) begin
                        res.dst.tag    = SH_AFF;
                        res.dst.base   = src_a.base * src_b.base;
                        res.dst.stride = src_a.base * src_b.stride;
                    end else if (a_aff && b_uni) begin
                        res.dst.tag    = SH_AFF;
                        res.dst.base   = src_a.base * src_b.base;
                        res.dst.stride = src_a.stride * src_b.base;
                    end
                end
                OP_LOAD: begin
                    res.wr_en       = 1'b1;
                    res.vec_access  = addr_aff;
                    res.unit_stride = addr_aff && (src_a.stride == DATA_W'(ELEM_BYTES));
                end
                OP_STORE: begin
                    res.vec_access  = addr_aff;
                    res.unit_stride = addr_aff && (src_a.stride == DATA_W'(ELEM_BYTES));
                end
                default: begin
                    res.wr_en = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vshape_tracker.sv
module vshape_tracker
    import shape_pkg::*;
#(
    parameter int ELEM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [2:0]        issue_op,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [DATA_W-1:0] imm,
    output logic              res_valid,
    output logic [1:0]        res_tag,
    output logic [DATA_W-1:0] res_base,
    output logic [DATA_W-1:0] res_stride,
    output logic              res_scalar,
    output logic              res_vec_access,
    output logic              res_unit_stride
);

    shape_t     rd_a, rd_b;
    shape_res_t comb_res;
    shape_res_t res_q;

    vshape_file #(.N_ENTRIES(NREG)) u_file (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (comb_res.wr_en),
        .wr_idx   (dst_idx),
        .wr_data  (comb_res.dst),
        .rd_a_idx (src_a_idx),
        .rd_b_idx (src_b_idx),
        .rd_a     (rd_a),
        .rd_b     (rd_b)
    );

    vshape_alu #(.ELEM_BYTES(ELEM_BYTES)) u_alu (
        .valid (issue_valid),
        .op    (issue_op),
        .src_a (rd_a),
        .src_b (rd_b),
        .imm   (imm),
        .res   (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            res_q.dst <= shape_unknown();
        end else begin
            res_q <= comb_res;
        end
    end

    assign res_valid       = res_q.valid;
    assign res_tag         = res_q.dst.tag;
    assign res_base        = res_q.dst.base;
    assign res_stride      = res_q.dst.stride;
    assign res_scalar      = res_q.valid & res_q.scalar;
    assign res_vec_access  = res_q.valid & res_q.vec_access;
    assign res_unit_stride = res_q.valid & res_q.unit_stride;

endmodule

// File: rtl/vshape_tracker_chk.sv
module vshape_tracker_chk
    import shape_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic [2:0]        issue_op,
    input logic              res_valid,
    input logic [1:0]        res_tag,
    input logic [DATA_W-1:0] res_base,
    input logic [DATA_W-1:0] res_stride,
    input logic              res_scalar,
    input logic              res_vec_access,
    input logic              res_unit_stride
);

    // R10
    result_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op <= 3'd5) |=> res_valid);

    // R11
    illegal_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue_valid && issue_op <= 3'd5) |=> !res_valid);

    // R2
    tid_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 3'd0) |=>
            (res_tag == 2'd1 && res_base == '0 && res_stride == DATA_W'(1)));

    // R7
    scalar_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        res_scalar |-> (res_valid && res_tag == 2'd0 && res_stride == '0));

    // R8
    unit_needs_vec_chk: assert property (@(posedge clk) disable iff (rst)
        res_unit_stride |-> res_vec_access);

    // R6
    unknown_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_tag == 2'd2) |-> (res_base == '0 && res_stride == '0 && !res_scalar));

    // R1
    tag_encoding_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tag != 2'd3));

endmodule

bind vshape_tracker vshape_tracker_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .issue_valid     (issue_valid),
    .issue_op        (issue_op),
    .res_valid       (res_valid),
    .res_tag         (res_tag),
    .res_base        (res_base),
    .res_stride      (res_stride),
    .res_scalar      (res_scalar),
    .res_vec_access  (res_vec_access),
    .res_unit_stride (res_unit_stride)
);

// File: tb/vshape_tracker_tb.sv
module vshape_tracker_tb;

    typedef struct packed {
        logic [1:0]  tag;
        logic [31:0] base;
        logic [31:0] stride;
        logic        scalar;
        logic        vec;
        logic        unit;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = '0;
    logic [3:0]  dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
    logic [31:0] imm = '0;
    logic        res_valid, res_scalar, res_vec_access, res_unit_stride;
    logic [1:0]  res_tag;
    logic [31:0] res_base, res_stride;

    int checks = 0;
    int fails  = 0;

    exp_t  exp_q[$];
    string req_q[$];

    logic [1:0]  m_tag [16];
    logic [31:0] m_base[16];
    logic [31:0] m_str [16];

    always #5 clk = ~clk;

    vshape_tracker u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .imm(imm),
        .res_valid(res_valid), .res_tag(res_tag), .res_base(res_base),
        .res_stride(res_stride), .res_scalar(res_scalar),
        .res_vec_access(res_vec_access), .res_unit_stride(res_unit_stride)
    );

    task automatic issue(input logic [2:0] op, input int d, input int a, input int b,
                         input logic [31:0] iv, input string req);
        exp_t e;
        logic [1:0] ta, tb;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_op    = op;
        dst_idx     = 4'(d);
        src_a_idx   = 4'(a);
        src_b_idx   = 4'(b);
        imm         = iv;
        ta = m_tag[a];
        tb = m_tag[b];
        e = '{tag: 2'd2, base: 32'd0, stride: 32'd0, scalar: 1'b0, vec: 1'b0, unit: 1'b0};
        case (op)
            3'd0: begin e.tag = 2'd1; e.stride = 32'd1; end
            3'd1: begin e.tag = 2'd0; e.base = iv; e.scalar = 1'b1; end
            3'd2: if (ta != 2'd2 && tb != 2'd2) begin
                e.tag    = (ta == 2'd0 && tb == 2'd0) ? 2'd0 : 2'd1;
                e.base   = m_base[a] + m_base[b];
                e.stride = m_str[a] + m_str[b];
                e.scalar = (e.tag == 2'd0);
            end
            3'd3: if (ta == 2'd0 && tb == 2'd0) begin
                e.tag = 2'd0; e.base = m_base[a] * m_base[b]; e.scalar = 1'b1;
            end else if (ta == 2'd0 && tb == 2'd1) begin
                e.tag = 2'd1; e.base = m_base[a] * m_base[b]; e.stride = m_base[a] * m_str[b];
            end else if (ta == 2'd1 && tb == 2'd0) begin
                e.tag = 2'd1; e.base = m_base[a] * m_base[b]; e.stride = m_str[a] * m_base[b];
            end
            3'd4, 3'd5: begin
                e.vec  = (ta == 2'd1);
                e.unit = (ta == 2'd1) && (m_str[a] == 32'd4);
            end
            default: ;
        endcase
        if (op <= 3'd4) begin
            m_tag[d]  = e.tag;
            m_base[d] = e.base;
            m_str[d]  = e.stride;
        end
        if (op <= 3'd5) begin
            exp_q.push_back(e);
            req_q.push_back(req);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (!rst && res_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11: unexpected result tag=%0d, expected none", res_tag);
                end else begin
                    exp_t  e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (res_tag !== e.tag || res_base !== e.base || res_stride !== e.stride ||
                        res_scalar !== e.scalar || res_vec_access !== e.vec ||
                        res_unit_stride !== e.unit) begin
                        fails++;
                        $display("FAIL %s: got tag=%0d base=%0d stride=%0d sc=%0b vec=%0b unit=%0b, expected tag=%0d base=%0d stride=%0d sc=%0b vec=%0b unit=%0b",
                                 r, res_tag, res_base, res_stride, res_scalar, res_vec_access,
                                 res_unit_stride, e.tag, e.base, e.stride, e.scalar, e.vec, e.unit);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        for (int i = 0; i < 16; i++) begin
            m_tag[i] = 2'd2; m_base[i] = '0; m_str[i] = '0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: res_valid=%0b during reset, expected 0", res_valid);
        end
        rst = 1'b0;
        issue(3'd2, 0, 1, 2, 0, "R1");        // reset tags are K
        issue(3'd3, 3, 4, 5, 0, "R1");
        issue(3'd0, 1, 0, 0, 0, "R2");        // tid move
        issue(3'd1, 2, 0, 0, 32'd5, "R3");    // immediate
        issue(3'd1, 3, 0, 0, 32'd4, "R3");
        issue(3'd2, 4, 1, 2, 0, "R4");        // A + U
        issue(3'd3, 5, 4, 3, 0, "R5_R10");    // back-to-back read of r4, A * U
        issue(3'd3, 15, 3, 4, 0, "R5");       // U * A
        issue(3'd2, 6, 2, 3, 0, "R7");        // U + U scalar
        issue(3'd3, 7, 2, 3, 0, "R7");        // U * U scalar
        issue(3'd2, 8, 4, 5, 0, "R4");        // A + A
        issue(3'd3, 9, 4, 5, 0, "R6");        // A * A -> K
        issue(3'd2, 10, 9, 2, 0, "R6");       // K + U
        issue(3'd3, 11, 2, 9, 0, "R6");       // U * K
        issue(3'd4, 12, 5, 0, 0, "R8");       // affine stride 4: vec + unit
        issue(3'd4, 13, 4, 0, 0, "R8");       // stride 1: vec only
        issue(3'd4, 14, 2, 0, 0, "R8");       // uniform address
        issue(3'd5, 2, 5, 3, 0, "R9");        // store, dst field names r2
        issue(3'd2, 13, 2, 2, 0, "R9");       // r2 still U(5)
        issue(3'd6, 2, 0, 0, 32'd99, "R11");  // illegal, no effect
        issue(3'd7, 3, 1, 1, 0, "R11");
        issue(3'd2, 14, 2, 3, 0, "R11");      // r2, r3 unchanged
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule